// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Line Ownership

This block controls a set of general-purpose I/O lines (32 by default) through a word-wide register port. It holds two register banks. One bank, the open bank, can always be reached. The other, the guarded bank, answers only while an external permission input is high. A per-line owner word chooses which bank drives each line's output value and output enable, and which bank watches that line for interrupts.

Each bank keeps output, direction, interrupt-level, interrupt-flag and interrupt-mask words. It also offers two read-only views of the synchronized pins. A flag bit latches whenever its owned line sits at the level programmed for it. Software clears a flag by writing a one to it. Each bank drives its own interrupt output, and that output is high whenever any flag in the bank is set and also unmasked.

An enable word sits in the guarded range and gates every output driver. The register port uses a word index, so there are no byte lanes. Read data returns one cycle after the request.

Top module: `gpio_dual_bank`

## Requirements
- R1: During and after reset, `gpio_out`, `gpio_oe`, both interrupt outputs and `bus_rdata` are zero. All bank words and the owner word reset to zero. The enable word resets to all ones.
- R2: Line i is driven from the open bank when owner bit i is 1, and from the guarded bank when it is 0. `gpio_out[i]` is the owning bank's output bit. `gpio_oe[i]` is the owning bank's direction bit ANDed with enable bit i. Both outputs are registered one cycle after the words they depend on.
- R3: Word indices 7 through 15 form the guarded range. This range covers the enable word, the owner word and the whole guarded bank. While `access_grant` is low, a read there returns zero and a write there changes nothing. Indices 0 through 6 always respond.
- R4: Writing a flag word clears each flag bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A flag bit is set on every cycle in which its bank owns the line and the synchronized input equals that bank's level bit (1 means active high, 0 means active low). A flag that is set and cleared in the same cycle stays set.
- R6: `irq_open` and `irq_guarded` are high one cycle after their bank holds any bit that is set in both its flag word and its mask word.
- R7: Pins pass through two flip-flop stages. The input word (index 2 in a bank) reads the synchronized pins ANDed with the lines that bank owns. The mirror word (index 6) reads every synchronized pin. Writes to either word are ignored.
- R8: `bus_rdata` loads on the clock edge that accepts a read and holds between reads.
- R9: `bus_widx[3]` selects the bank (0 open, 1 guarded). `bus_widx[2:0]` selects the word: 0 output, 1 direction, 2 input, 3 level, 4 flag, 5 mask, 6 mirror. Word 7 is the enable word in the open half and the owner word in the guarded half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| access_grant | input | 1 | Permission to reach the guarded range |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_widx | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Read data, one cycle after the read |
| gpio_in | input | NUM_LINES | Asynchronous pin levels |
| gpio_out | output | NUM_LINES | Output values to the pads |
| gpio_oe | output | NUM_LINES | Output enables to the pads |
| irq_open | output | 1 | Open-bank interrupt |
| irq_guarded | output | 1 | Guarded-bank interrupt |

## Verification
The assertions assume two things. First, `access_grant` and the request fields are stable, synchronous values at each clock edge. Second, a request in one cycle is either a read or a write, never both. The bench drives every input at the falling edge from one task, so every edge sees settled values. The random phase picks word indices across all sixteen slots and lowers the grant often, so gated and ungated requests to the guarded range both occur. Pin levels change only now and then, so levels held across several cycles arise and the synchronizer and level behaviour can be seen.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    W_OUT     = 3'd0,
    W_DIR     = 3'd1,
    W_IN      = 3'd2,
    W_LVL     = 3'd3,
    W_FLAG    = 3'd4,
    W_MASK    = 3'd5,
    W_MIRROR  = 3'd6,
    W_SPECIAL = 3'd7
  } word_e;

  localparam int NUM_BANKS = 2;
  localparam int BANK_OPEN = 0;
  localparam int BANK_GUARDED = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  word_e        idx,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] own,
  input  logic [N-1:0] in_sync,
  output logic [N-1:0] out_q,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] rd_data,
  output logic         irq_q
);
  logic [N-1:0] lvl_q;
  logic [N-1:0] flag_q;
  logic [N-1:0] clr;
  logic [N-1:0] hit;

  always_comb begin
    clr = (wr_en && idx == W_FLAG) ? wr_data : '0;
    hit = own & ~(in_sync ^ lvl_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      lvl_q  <= '0;
      mask_q <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr) | hit;
      irq_q  <= |(flag_q & mask_q);
      if (wr_en) begin
        case (idx)
          W_OUT:   out_q  <= wr_data;
          W_DIR:   dir_q  <= wr_data;
          W_LVL:   lvl_q  <= wr_data;
          W_MASK:  mask_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      W_OUT:    rd_data = out_q;
      W_DIR:    rd_data = dir_q;
      W_IN:     rd_data = in_sync & own;
      W_LVL:    rd_data = lvl_q;
      W_FLAG:   rd_data = flag_q;
      W_MASK:   rd_data = mask_q;
      W_MIRROR: rd_data = in_sync;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 access_grant,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [3:0]           bus_widx,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] gpio_in,
  output logic [NUM_LINES-1:0] gpio_out,
  output logic [NUM_LINES-1:0] gpio_oe,
  output logic                 irq_open,
  output logic                 irq_guarded
);
  localparam int N = NUM_LINES;

  logic [N-1:0] in_sync;
  logic [N-1:0] owner_q;
  logic [N-1:0] en_q;
  word_e        idx;
  logic         bank_sel;
  logic         guarded;
  logic         allowed;
  logic         wr_ok;
  logic [N-1:0] rd_mux;

  logic [N-1:0] bank_out  [NUM_BANKS];
  logic [N-1:0] bank_dir  [NUM_BANKS];
  logic [N-1:0] bank_mask [NUM_BANKS];
  logic [N-1:0] bank_rd   [NUM_BANKS];
  logic         bank_irq  [NUM_BANKS];
  logic         bank_we   [NUM_BANKS];

  gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (gpio_in),
    .q   (in_sync)
  );

  always_comb begin
    idx      = word_e'(bus_widx[2:0]);
    bank_sel = bus_widx[3];
    guarded  = bank_sel || (idx == W_SPECIAL);
    allowed  = !guarded || access_grant;
    wr_ok    = bus_valid && bus_write && allowed;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = wr_ok && (bank_sel == 1'(b)) && (idx != W_SPECIAL);

    gpio_bank #(.N(N)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bank_we[b]),
      .idx     (idx),
      .wr_data (bus_wdata),
      .own     ((b == BANK_OPEN) ? owner_q : ~owner_q),
      .in_sync (in_sync),
      .out_q   (bank_out[b]),
      .dir_q   (bank_dir[b]),
      .mask_q  (bank_mask[b]),
      .rd_data (bank_rd[b]),
      .irq_q   (bank_irq[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
      en_q    <= '1;
    end else if (wr_ok && idx == W_SPECIAL) begin
      if (bank_sel) owner_q <= bus_wdata;
      else          en_q    <= bus_wdata;
    end
  end

  always_comb begin
    if (!allowed)              rd_mux = '0;
    else if (idx == W_SPECIAL) rd_mux = bank_sel ? owner_q : en_q;
    else                       rd_mux = bank_rd[bank_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      gpio_out  <= '0;
      gpio_oe   <= '0;
    end else begin
      if (bus_valid && !bus_write) bus_rdata <= rd_mux;
      gpio_out <= (owner_q & bank_out[BANK_OPEN]) | (~owner_q & bank_out[BANK_GUARDED]);
      gpio_oe  <= en_q & ((owner_q & bank_dir[BANK_OPEN]) |
                          (~owner_q & bank_dir[BANK_GUARDED]));
    end
  end

  assign irq_open    = bank_irq[BANK_OPEN];
  assign irq_guarded = bank_irq[BANK_GUARDED];
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         access_grant,
  input logic         bus_valid,
  input logic         bus_write,
  input logic [3:0]   bus_widx,
  input logic [N-1:0] bus_rdata,
  input logic [N-1:0] gpio_oe,
  input logic         irq_open,
  input logic         irq_guarded,
  input logic [N-1:0] owner_q,
  input logic [N-1:0] en_q,
  input logic [N-1:0] open_mask,
  input logic [N-1:0] guarded_mask
);
  logic in_guarded;
  assign in_guarded = bus_widx[3] || (bus_widx[2:0] == 3'd7);

  AST_GATED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && !access_grant && in_guarded) |=> (bus_rdata == '0)); // R3

  AST_GATED_OWNER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!access_grant) |=> $stable(owner_q)); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R8

  AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ((gpio_oe & ~$past(en_q)) == '0)); // R2

  AST_IRQ_OPEN_MASKED: assert property (@(posedge clk) disable iff (rst)
    (open_mask == '0) |=> !irq_open); // R6

  AST_IRQ_GUARDED_MASKED: assert property (@(posedge clk) disable iff (rst)
    (guarded_mask == '0) |=> !irq_guarded); // R6
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.N(NUM_LINES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .access_grant (access_grant),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_widx     (bus_widx),
  .bus_rdata    (bus_rdata),
  .gpio_oe      (gpio_oe),
  .irq_open     (irq_open),
  .irq_guarded  (irq_guarded),
  .owner_q      (owner_q),
  .en_q         (en_q),
  .open_mask    (bank_mask[0]),
  .guarded_mask (bank_mask[1])
);

// File: tb/tb_gpio_dual_bank.sv
module tb_gpio_dual_bank;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         access_grant;
  logic         bus_valid;
  logic         bus_write;
  logic [3:0]   bus_widx;
  logic [N-1:0] bus_wdata;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] gpio_in;
  logic [N-1:0] gpio_out;
  logic [N-1:0] gpio_oe;
  logic         irq_open;
  logic         irq_guarded;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  gpio_dual_bank #(.NUM_LINES(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .access_grant(access_grant),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_widx(bus_widx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .irq_open(irq_open), .irq_guarded(irq_guarded)
  );

  // reference state, bank 0 = open, bank 1 = guarded
  logic [N-1:0] m_out [2];
  logic [N-1:0] m_dir [2];
  logic [N-1:0] m_lvl [2];
  logic [N-1:0] m_flag [2];
  logic [N-1:0] m_mask [2];
  logic         m_irq [2];
  logic [N-1:0] m_owner, m_en, m_s1, m_s2, m_gout, m_goe, m_rdata;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] own_of(input int b);
    return (b == 0) ? m_owner : ~m_owner;
  endfunction

  function automatic logic [N-1:0] ref_read(input logic [3:0] wi, input logic g);
    int b = int'(wi[3]);
    logic [2:0] w = wi[2:0];
    if ((wi[3] || w == 3'd7) && !g) return '0;
    case (w)
      3'd0: return m_out[b];
      3'd1: return m_dir[b];
      3'd2: return m_s2 & own_of(b);
      3'd3: return m_lvl[b];
      3'd4: return m_flag[b];
      3'd5: return m_mask[b];
      3'd6: return m_s2;
      default: return wi[3] ? m_owner : m_en;
    endcase
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 2; b++) begin
      m_out[b] = '0; m_dir[b] = '0; m_lvl[b] = '0;
      m_flag[b] = '0; m_mask[b] = '0; m_irq[b] = 1'b0;
    end
    m_owner = '0; m_en = '1; m_s1 = '0; m_s2 = '0;
    m_gout = '0; m_goe = '0; m_rdata = '0;
  endtask

  task automatic cyc(input logic v, input logic w, input logic [3:0] wi,
                     input logic [N-1:0] d, input logic g, input logic [N-1:0] gi);
    logic [N-1:0] nf [2];
    logic         ni [2];
    logic [N-1:0] n_gout, n_goe, clr;
    logic         ok;
    bus_valid = v; bus_write = w; bus_widx = wi; bus_wdata = d;
    access_grant = g; gpio_in = gi;
    @(posedge clk);
    ok = !(wi[3] || wi[2:0] == 3'd7) || g;
    for (int b = 0; b < 2; b++) begin
      clr = (v && w && ok && int'(wi[3]) == b && wi[2:0] == 3'd4) ? d : '0;
      nf[b] = (m_flag[b] & ~clr) | (own_of(b) & ~(m_s2 ^ m_lvl[b]));
      ni[b] = |(m_flag[b] & m_mask[b]);
    end
    n_gout = (m_owner & m_out[0]) | (~m_owner & m_out[1]);
    n_goe  = m_en & ((m_owner & m_dir[0]) | (~m_owner & m_dir[1]));
    if (v && !w) m_rdata = ref_read(wi, g);
    if (v && w && ok) begin
      case (wi[2:0])
        3'd0: m_out[wi[3]]  = d;
        3'd1: m_dir[wi[3]]  = d;
        3'd3: m_lvl[wi[3]]  = d;
        3'd5: m_mask[wi[3]] = d;
        3'd7: if (wi[3]) m_owner = d; else m_en = d;
        default: ;
      endcase
    end
    m_s2 = m_s1; m_s1 = gi;
    for (int b = 0; b < 2; b++) begin m_flag[b] = nf[b]; m_irq[b] = ni[b]; end
    m_gout = n_gout; m_goe = n_goe;
    @(negedge clk);
    check("R2 gpio_out", gpio_out, m_gout);
    check("R2 gpio_oe", gpio_oe, m_goe);
    check("R6 irq_open", {{(N-1){1'b0}}, irq_open}, {{(N-1){1'b0}}, m_irq[0]});
    check("R6 irq_guarded", {{(N-1){1'b0}}, irq_guarded}, {{(N-1){1'b0}}, m_irq[1]});
    check("R8 bus_rdata", bus_rdata, m_rdata);
  endtask

  task automatic wr(input logic [3:0] wi, input logic [N-1:0] d, input logic g);
    cyc(1'b1, 1'b1, wi, d, g, gpio_in);
  endtask
  task automatic rd(input logic [3:0] wi, input logic g);
    cyc(1'b1, 1'b0, wi, '0, g, gpio_in);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h0, '0, 1'b0, gpio_in);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; access_grant = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_widx = '0; bus_wdata = '0; gpio_in = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset gpio_oe", gpio_oe, '0);
    check("R1 reset rdata", bus_rdata, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 gpio_out after reset", gpio_out, '0);

    // R1 / R9 reset values of special words
    rd(4'hF, 1'b1); check("R1 R9 owner reset", bus_rdata, 32'h0);
    rd(4'h7, 1'b1); check("R1 R9 enable reset", bus_rdata, 32'hFFFF_FFFF);

    // R3 gated writes ignored, gated reads zero
    wr(4'hF, 32'hFFFF_FFFF, 1'b0);
    rd(4'hF, 1'b1); check("R3 owner after gated write", bus_rdata, 32'h0);
    wr(4'h7, 32'h0, 1'b0);
    rd(4'h7, 1'b1); check("R3 enable after gated write", bus_rdata, 32'hFFFF_FFFF);
    rd(4'h7, 1'b0); check("R3 gated read of enable", bus_rdata, 32'h0);

    // R5 level flags and R4 write-one-to-clear, guarded bank owns all lines
    gpio_in = 32'h0000_000F;
    wr(4'hB, 32'hFFFF_FFFF, 1'b1);
    idle(4);
    wr(4'hC, 32'hFFFF_FFFF, 1'b1);
    idle(2);
    rd(4'hC, 1'b1); check("R5 flag resets while level held", bus_rdata, 32'h0000_000F);
    gpio_in = 32'h0;
    idle(4);
    wr(4'hC, 32'h0000_0003, 1'b1);
    rd(4'hC, 1'b1); check("R4 partial clear", bus_rdata, 32'h0000_000C);
    wr(4'hC, 32'h0, 1'b1);
    rd(4'hC, 1'b1); check("R4 zero write no effect", bus_rdata, 32'h0000_000C);

    // R7 input views
    gpio_in = 32'hA5A5_0000;
    idle(3);
    rd(4'h2, 1'b0); check("R7 open input, unowned lines", bus_rdata, 32'h0);
    rd(4'h6, 1'b0); check("R7 open mirror", bus_rdata, 32'hA5A5_0000);
    rd(4'hA, 1'b1); check("R7 guarded input", bus_rdata, 32'hA5A5_0000);
    wr(4'h6, 32'hFFFF_FFFF, 1'b0);
    rd(4'h6, 1'b0); check("R7 mirror write ignored", bus_rdata, 32'hA5A5_0000);

    // R2 ownership routing
    wr(4'hF, 32'hFFFF_0000, 1'b1);
    wr(4'h0, 32'h1234_5678, 1'b0);
    wr(4'h1, 32'hFFFF_FFFF, 1'b0);
    wr(4'h8, 32'h8765_4321, 1'b1);
    wr(4'h9, 32'h0000_FFFF, 1'b1);
    idle(1);
    check("R2 routed gpio_out", gpio_out, 32'h1234_4321);
    check("R2 routed gpio_oe", gpio_oe, 32'hFFFF_FFFF);

    // R6 open-bank interrupt on a low level
    gpio_in = 32'h0;
    wr(4'h3, 32'h0, 1'b0);
    wr(4'h5, 32'h0001_0000, 1'b0);
    idle(4);
    check("R6 irq_open raised", {31'b0, irq_open}, 32'h1);
    wr(4'h5, 32'h0, 1'b0);
    idle(2);
    check("R6 irq_open masked", {31'b0, irq_open}, 32'h0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] gi = gpio_in;
      if (($urandom % 8) == 0) gi = $urandom;
      cyc(($urandom % 10) < 6, $urandom % 2, 4'($urandom % 16), $urandom,
          ($urandom % 10) < 7, gi);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule